// File: doc/BRIEF.md
# Nibble-Reordered Colour Palette

This block holds a sixteen-entry colour table and turns a 4-bit pixel index into three linear 4-bit channel levels (red, green, blue). A host writes entries through a simple strobe port and can read any entry back at any time through a separate read index. The lookup path is registered, so a pixel index presented in one cycle yields its colour levels on the following cycle.

Each stored channel nibble keeps its smallest weight in its top bit and the three larger weights in the lower three bits. Software written for a 3-bit-per-channel palette therefore gets the same brightness, and a fourth bit adds a half step. The block undoes this ordering on the lookup path so that the outputs are plain binary levels. The host read port returns the raw stored bits, not the decoded levels.

The design is a register file, one decoder per channel and a top level that selects entries for the host read and the pixel lookup. It has no state machine: the only sequential behaviour is entry storage and the one-cycle lookup register.

Top module: `nib_palette`

## Requirements
- R1: While reset is asserted and after it is released, every entry reads as 0x0000 and the lookup outputs are 0 until an entry is written.
- R2: A write with `wr_en` high stores `wr_data[11:0]` into entry `wr_idx`. Bits 15..12 of the write data are discarded. `rd_data` always shows bits 15..12 as zero and bits 11..0 as the stored word of entry `rd_idx`.
- R3: A write changes only the addressed entry; all other fifteen entries keep their contents.
- R4: Within a stored word, bits 11..8 hold the red nibble, bits 7..4 hold the green nibble and bits 3..0 hold the blue nibble. Each nibble drives its own output channel.
- R5: For a stored nibble n, the output level is 8·n[2] + 4·n[1] + 2·n[0] + 1·n[3].
- R6: The grey ramp 0x000, 0x888, 0x111, 0x999, 0x222, 0xAAA, 0x333, 0xBBB, 0x444, 0xCCC, 0x555, 0xDDD, 0x666, 0xEEE, 0x777, 0xFFF gives levels 0, 1, 2, … 15 on all three channels, rising by exactly one at each step.
- R7: A nibble with bit 3 clear and value v in bits 2..0 gives level 2·v (always even).
- R8: The colour outputs update at the clock edge after `pix_idx` is presented. A write at one edge is not yet seen by the lookup sampled at that same edge. The lookup sampled at the next edge shows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | 4 | Entry written when `wr_en` is high |
| wr_data | input | 16 | Write word; bits 15..12 are discarded |
| rd_idx | input | 4 | Entry shown on `rd_data` |
| rd_data | output | 16 | Stored word of entry `rd_idx`, zero-extended |
| pix_idx | input | 4 | Pixel colour index for the lookup |
| red | output | 4 | Linear red level, registered |
| green | output | 4 | Linear green level, registered |
| blue | output | 4 | Linear blue level, registered |

## Verification
The assertions assume that `wr_en`, `wr_idx` and `pix_idx` are known (not X) at every rising edge after reset. They also assume that reset is asserted from time zero until at least one edge has passed. The bench meets this by setting every input at time zero and changing inputs only on falling edges. It then sweeps all 4096 colour words through the table with varied junk in the discarded top bits, and compares every read and lookup against levels it computes from bit weights.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int unsigned CH_W     = 4;
    localparam int unsigned NUM_CH   = 3;
    localparam int unsigned COLOR_W  = CH_W * NUM_CH;

    // Stored nibble keeps its weight-1 bit at the top; rotate it down.
    function automatic logic [CH_W-1:0] nib_to_level(input logic [CH_W-1:0] nib);
        return {nib[CH_W-2:0], nib[CH_W-1]};
    endfunction

endpackage

// File: rtl/pal_entry_file.sv
module pal_entry_file #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned COLOR_W = 12,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [COLOR_W-1:0]               wr_color,
    output logic [ENTRIES-1:0][COLOR_W-1:0]  entries_q
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entries_q[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                entries_q[e] <= wr_color;
            end
        end

        // R1: reset leaves every entry black
        a_r1_reset_black: assert property (@(posedge clk)
            !rst_n |=> (entries_q[e] == '0));

        // R2: an addressed write lands in the entry
        a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(e)) |=> (entries_q[e] == $past(wr_color)));

        // R3: other entries are untouched
        a_r3_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(e)) |=> $stable(entries_q[e]));
    end

endmodule

// File: rtl/pal_chan_decode.sv
module pal_chan_decode
    import pal_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_W-1:0] nib,
    output logic [CH_W-1:0] level_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            level_q <= nib_to_level(nib);
        end
    end

    // R7: without the half-step bit the level is even
    a_r7_even_level: assert property (@(posedge clk) disable iff (!rst_n)
        (nib[CH_W-1] == 1'b0) |=> (level_q[0] == 1'b0));

    // R5: the top stored bit alone is the smallest step
    a_r5_top_is_one: assert property (@(posedge clk) disable iff (!rst_n)
        (nib == 4'b1000) |=> (level_q == 4'd1));

    // R5: the lowest stored bit alone is weight two
    a_r5_low_is_two: assert property (@(posedge clk) disable iff (!rst_n)
        (nib == 4'b0001) |=> (level_q == 4'd2));

endmodule

// File: rtl/nib_palette.sv
module nib_palette
    import pal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_idx,
    input  logic [15:0] wr_data,
    input  logic [3:0]  rd_idx,
    output logic [15:0] rd_data,
    input  logic [3:0]  pix_idx,
    output logic [3:0]  red,
    output logic [3:0]  green,
    output logic [3:0]  blue
);

    localparam int unsigned ENTRIES = 16;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned PAD_W   = DATA_W - COLOR_W;

    logic [ENTRIES-1:0][COLOR_W-1:0] entries;
    logic [COLOR_W-1:0]              pix_color;
    logic [NUM_CH-1:0][CH_W-1:0]     levels;

    pal_entry_file #(
        .ENTRIES (ENTRIES),
        .COLOR_W (COLOR_W)
    ) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_color  (wr_data[COLOR_W-1:0]),
        .entries_q (entries)
    );

    always_comb begin
        rd_data   = {{PAD_W{1'b0}}, entries[rd_idx]};
        pix_color = entries[pix_idx];
    end

    // Channel c takes nibble c, counted from the bottom (blue = 0).
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        pal_chan_decode u_dec (
            .clk     (clk),
            .rst_n   (rst_n),
            .nib     (pix_color[c*CH_W +: CH_W]),
            .level_q (levels[c])
        );
    end

    assign blue  = levels[0];
    assign green = levels[1];
    assign red   = levels[2];

    // R8: a black entry looked up gives black one cycle later
    a_r8_black_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_color == '0) |=> (red == '0 && green == '0 && blue == '0));

endmodule

// File: tb/nib_palette_tb_top.sv
module nib_palette_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic [3:0]  pix_idx = '0;
    logic [3:0]  red, green, blue;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [11:0] model [16];

    always #10 clk = ~clk;

    nib_palette dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .pix_idx(pix_idx), .red(red), .green(green), .blue(blue)
    );

    function automatic int lvl(input logic [3:0] n);
        return (n[3] ? 1 : 0) + (n[2] ? 8 : 0) + (n[1] ? 4 : 0) + (n[0] ? 2 : 0);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_rgb(input string req, input logic [11:0] w);
        chk(int'(red)   == lvl(w[11:8]), req, int'(red),   lvl(w[11:8]));
        chk(int'(green) == lvl(w[7:4]),  req, int'(green), lvl(w[7:4]));
        chk(int'(blue)  == lvl(w[3:0]),  req, int'(blue),  lvl(w[3:0]));
    endtask

    // Write at one edge with pix_idx on the same entry; return at the next negedge.
    task automatic put(input logic [3:0] i, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_data = d; pix_idx = i; rd_idx = i;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [3:0] i);
        @(negedge clk);
        pix_idx = i;
        @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        // R1: entries black while in reset
        for (int k = 0; k < 16; k++) begin
            rd_idx = 4'(k); #1;
            chk(rd_data == 16'h0, "R1 reset read", int'(rd_data), 0);
        end
        rst_n = 1'b1;
        look(4'd5);
        chk_rgb("R1 reset lookup", 12'h000);

        // R2 R4 R5 R8: every colour word, junk in top bits
        for (int v = 0; v < 4096; v++) begin
            logic [3:0]  e;
            logic [15:0] d;
            e = 4'(v);
            d = {4'(v) ^ 4'hA, 12'(v)};
            put(e, d);
            chk(rd_data == {4'h0, 12'(v)}, "R2 readback", int'(rd_data), v);
            chk_rgb("R8 old value at write edge", model[e]);
            model[e] = 12'(v);
            @(negedge clk);
            chk_rgb("R4 R5 decoded lookup", 12'(v));
        end

        // R3: each entry kept its own last word
        for (int k = 0; k < 16; k++) begin
            rd_idx = 4'(k); #1;
            chk(rd_data[11:0] == model[k], "R3 entry kept", int'(rd_data), int'(model[k]));
        end

        // R6: grey ramp gives 0..15
        for (int s = 0; s < 16; s++) begin
            logic [3:0] n;
            n = {s[0], 3'(s >> 1)};
            put(4'(s), {4'hF, n, n, n});
            model[s] = {n, n, n};
        end
        for (int s = 0; s < 16; s++) begin
            look(4'(s));
            chk(int'(red) == s && int'(green) == s && int'(blue) == s,
                "R6 grey ramp", int'({red, green, blue}), s * 273);
        end

        // R7: 3-bit compatible values give twice the level
        for (int v = 0; v < 8; v++) begin
            logic [3:0] n;
            n = 4'(v);
            put(4'd9, {4'h0, n, n, n});
            @(negedge clk);
            chk(int'(red) == 2 * v && int'(blue) == 2 * v, "R7 doubled step",
                int'(red), 2 * v);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule